// File: doc/BRIEF.md
# Streaming Packet Framing Checker

This block sits on a valid/ready stream that carries framed packets of complex samples. Each beat has a signed real part, a signed imaginary part, a start marker and an end marker. The checker tracks whether a packet is currently open. It classifies every accepted beat as clean or as one of three framing faults, and sends the beat on to a downstream sink. A beat is dropped when it cannot belong to any packet.

The handshake is not buffered. The upstream ready is the downstream ready in the same cycle, and beats that are passed appear at the output in the same cycle. The fault class of each accepted beat is reported on a registered two-bit code one clock later. The sample precision is a parameter. The reset is active low and asserts asynchronously, and its release must be aligned to the clock.

Top module: `pkt_frame_checker`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, err_code is 2'b00 and no packet is open. A beat accepted right after reset with neither marker set is therefore reported as 2'b01.
- R2: A beat is accepted only in a cycle where in_valid and in_ready are both high. Cycles without acceptance leave the open/closed state unchanged.
- R3: in_ready equals out_ready in the same cycle.
- R4: A clean beat drives out_valid high in the same cycle, with in_sop, in_eop, in_re and in_im copied unchanged to out_sop, out_eop, out_re and out_im. A beat with no start marker inside an open packet is clean, and so is a beat with only an end marker inside an open packet. The end-marker beat closes the packet.
- R5: A beat with neither marker set, accepted while no packet is open, is reported as code 2'b01 (missing start). It is dropped (out_valid low), and the state stays closed.
- R6: A beat with the start marker set, accepted while a packet is open, is reported as code 2'b10 (missing end). It is still passed downstream. The old packet is closed, and a new packet is opened unless the beat also has the end marker set.
- R7: A beat with only the end marker set, accepted while no packet is open, is reported as code 2'b11 (unexpected end). It is dropped, and the state stays closed.
- R8: A beat with both markers set, accepted while no packet is open, is a clean one-beat packet (code 2'b00). It is passed and leaves the state closed.
- R9: err_code is registered. In the clock after an accepted beat it shows that beat's code. In the clock after a cycle with no accepted beat it shows 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, clock-aligned release |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream may transfer (equals out_ready) |
| in_sop | input | 1 | Start-of-packet marker of the upstream beat |
| in_eop | input | 1 | End-of-packet marker of the upstream beat |
| in_re | input | DW | Signed real sample |
| in_im | input | DW | Signed imaginary sample |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream can accept |
| out_sop | output | 1 | Forwarded start marker |
| out_eop | output | 1 | Forwarded end marker |
| out_re | output | DW | Forwarded real sample |
| out_im | output | DW | Forwarded imaginary sample |
| err_code | output | 2 | Registered fault code of the previous accepted beat |

## Verification
Two functions can fall in the same cycle. A start-marked beat that arrives inside an open packet both raises the missing-end fault and opens the next packet, and it is passed downstream in the same cycle. The bench provokes this with back-to-back starts, with start-plus-end beats inside an open packet, and with faulty beats held under downstream backpressure. A held beat must not be classified until ready returns. A behavioural model keeps its own open flag and is compared against every output on every clock. It must agree on the pass/drop decision in the beat's own cycle and on the fault code one clock later.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;
  typedef enum logic [1:0] {
    FE_NONE  = 2'b00,
    FE_NOSOP = 2'b01,
    FE_NOEOP = 2'b10,
    FE_BADEOP = 2'b11
  } frame_err_t;
endpackage

// File: rtl/frm_classify.sv
module frm_classify
  import pkt_frame_pkg::*;
(
  input  logic       open_q,
  input  logic       sop,
  input  logic       eop,
  output frame_err_t code,
  output logic       pass,
  output logic       open_d
);
  always_comb begin
    code   = FE_NONE;
    pass   = 1'b1;
    open_d = open_q;
    if (sop) begin
      code   = open_q ? FE_NOEOP : FE_NONE;
      open_d = !eop;
    end else if (eop) begin
      if (open_q) begin
        open_d = 1'b0;
      end else begin
        code = FE_BADEOP;
        pass = 1'b0;
      end
    end else if (!open_q) begin
      code = FE_NOSOP;
      pass = 1'b0;
    end
  end
endmodule

// File: rtl/frm_state.sv
module frm_state (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic open_d,
  output logic open_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      open_q <= 1'b0;
    else if (accept) open_q <= open_d;
  end
endmodule

// File: rtl/frm_errreg.sv
module frm_errreg
  import pkt_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  frame_err_t code,
  output logic [1:0] err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 2'b00;
    else if (accept) err_q <= code;
    else             err_q <= 2'b00;
  end
endmodule

// File: rtl/pkt_frame_checker.sv
module pkt_frame_checker
  import pkt_frame_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sop,
  output logic          out_eop,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic [1:0]    err_code
);
  frame_err_t code;
  logic       pass, open_d, open_q, accept;

  assign in_ready = out_ready;
  assign accept   = in_valid && out_ready;

  frm_classify u_cls (
    .open_q(open_q), .sop(in_sop), .eop(in_eop),
    .code(code), .pass(pass), .open_d(open_d)
  );

  frm_state u_st (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .open_d(open_d), .open_q(open_q)
  );

  frm_errreg u_err (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .code(code), .err_q(err_code)
  );

  assign out_valid = in_valid && pass;
  assign out_sop   = in_sop;
  assign out_eop   = in_eop;
  assign out_re    = in_re;
  assign out_im    = in_im;

  // R9: no accepted beat means quiet code next clock
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> err_code == 2'b00);

  // R5/R7: a dropped accepted beat is always a missing-start or unexpected-end fault
  assert_drop_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> err_code[0]);

  // R4: a passed beat never carries a drop-class code
  assert_pass_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid) |=> !err_code[0]);

  // R6: a start-marked beat is always forwarded
  assert_sop_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |-> out_valid);

  // R7: an end-only beat after a clean closing end is reported unexpected
  assert_double_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop && !in_sop && out_valid) ##1
    (in_valid && in_ready && in_eop && !in_sop) |=> err_code == 2'b11);
endmodule

// File: tb/sim_pkt_frame_checker.sv
module sim_pkt_frame_checker;
  localparam int DW = 12;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_re, out_im;
  logic [1:0] err_code;

  int checks = 0, errors = 0;
  bit m_open = 0;
  int m_err = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  pkt_frame_checker #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_re(out_re), .out_im(out_im), .err_code(err_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, advance model
  task automatic beat(input bit v, input bit s, input bit e, input bit rdy);
    int cls; bit pass; bit nopen; string tag;
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; out_ready = rdy;
    in_re = DW'($urandom); in_im = DW'($urandom);
    #1;
    cls = 0; pass = 1; nopen = m_open;
    if (s) begin cls = m_open ? 2 : 0; nopen = !e; end
    else if (e) begin
      if (m_open) nopen = 0; else begin cls = 3; pass = 0; end
    end else if (!m_open) begin cls = 1; pass = 0; end
    case (cls)
      1: tag = "R5"; 2: tag = "R6"; 3: tag = "R7";
      default: tag = (s && e) ? "R8" : "R4";
    endcase
    chk("R9", "err_code", int'(err_code), m_err);
    chk("R3", "in_ready", int'(in_ready), int'(rdy));
    chk(tag, "out_valid", int'(out_valid), int'(v && pass));
    if (v && pass) begin
      chk("R4", "out_re", int'(out_re), int'(in_re));
      chk("R4", "out_im", int'(out_im), int'(in_im));
      chk("R4", "out_sop", int'(out_sop), int'(s));
      chk("R4", "out_eop", int'(out_eop), int'(e));
    end
    if (v && rdy) begin m_err = cls; m_open = nopen; end
    else m_err = 0; // R2: idle cycle leaves m_open
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "err_code in reset", int'(err_code), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: closed after reset -> no-marker beat is missing start
    beat(1,0,0,1);
    beat(0,0,0,1);
    // normal packet with idle and backpressure (R2)
    beat(1,1,0,1); beat(1,0,0,1); beat(0,0,0,1); beat(1,0,0,0);
    beat(1,0,1,1);
    // R7 unexpected end, R5 missing start, R8 single beat
    beat(1,0,1,1); beat(1,0,0,1); beat(1,1,1,1); beat(1,0,0,1);
    // R6 back-to-back starts, then sop+eop inside open packet
    beat(1,1,0,1); beat(1,1,0,1); beat(1,1,1,1); beat(1,0,0,1);
    // R2 fault beat held under backpressure is not classified
    beat(1,0,1,0); beat(1,0,1,0); beat(1,0,1,1); beat(0,0,0,1);
    // R1 asynchronous reset inside an open packet
    beat(1,1,0,1);
    #2 rst_n = 1'b0; m_open = 0; m_err = 0;
    #1 chk("R1", "err_code async reset", int'(err_code), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    beat(0,0,0,1);
    beat(1,0,0,1);
    // random traffic
    for (int i = 0; i < 400; i++)
      beat($urandom_range(0,3) != 0, $urandom_range(0,3) == 0,
           $urandom_range(0,3) == 0, $urandom_range(0,4) != 0);
    beat(0,0,0,1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule